// File: doc/BRIEF.md
# DMA Trigger Router with Channel Chaining

This block decides when each channel of a small DMA engine moves its next data item. Every channel chooses one of several asynchronous request lines as its trigger. Each new rising edge on that line produces one transfer request to the data mover. The channel then waits for the mover's done handshake and counts down a transfer-size register. When the count runs out, the channel disarms itself and raises a sticky completion flag.

A channel can be told to hand over to the channel numbered one above it. Its completion then gives that channel a one-cycle internal trigger. This lets, for example, a receive-to-memory channel start a memory-to-checker channel with no software step in between. The trigger selection of an armed channel cannot be changed. A request line that is already high when a channel is armed is not taken as a trigger.

Software configures channels through a single write port. The port selects a channel and one of three actions: write control, write size, or clear the completion flag.

Top module: `dma_trig_router`

## Requirements
- R1: A control write (`wr_sel`=0) sets enable from `wr_data[0]`, chain from `wr_data[1]` and the trigger line index from `wr_data[4:2]`. A rising edge on the selected `trig_i` line, seen through a two-flop synchroniser, raises `xfer_req_o` for an armed, idle channel. Edges on other lines do nothing.
- R2: A raised request stays high until that channel's `xfer_done_i` is sampled high. Each handshake lowers the request and reduces the remaining count by one. Trigger edges that arrive while a request is outstanding are dropped.
- R3: While a channel is enabled, a control write leaves its trigger index unchanged, and a size write (`wr_sel`=1) leaves its remaining count unchanged.
- R4: A selected line that is already high when the channel is enabled does not trigger it. Only a later rising edge counts.
- R5: The handshake that brings the count to zero clears the channel's enable and sets `done_o`. Later triggers raise no request until the channel is re-armed.
- R6: `done_o` stays set until a clear write (`wr_sel`=2) to that channel. If completion and the clear write happen in the same cycle, the flag ends up set.
- R7: Completion of channel i with chain set gives channel i+1 a one-cycle trigger, which starts a transfer there if it is armed. A chain trigger and an external edge that arrive together produce one request.
- R8: Channel 0 receives no chain trigger, and the completion of the last channel triggers no channel, whatever its chain bit.
- R9: A channel armed with a count of zero completes within two cycles without raising a request, and passes on a chain trigger if chain is set.
- R10: After reset, all channels are disabled, with no requests, no completion flags and a count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W (2) | Channel addressed by the write |
| wr_sel | input | 2 | 0 control, 1 size, 2 clear completion flag, 3 no action |
| wr_data | input | SIZE_W (8) | Write data |
| trig_i | input | NUM_TRIG (8) | Asynchronous request lines |
| xfer_req_o | output | NUM_CH (4) | Per-channel transfer request |
| xfer_done_i | input | NUM_CH (4) | Per-channel transfer done handshake |
| done_o | output | NUM_CH (4) | Per-channel sticky completion flag |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a clear-flag write and the final handshake. The bench drives both in one cycle while a request is outstanding. It expects the completion flag to be set afterwards.

The second pair is a chain trigger and an external edge into the same channel. The bench sets the downstream channel's request line in the same cycle as the upstream zero-count arming write. The synchroniser delay and the completion delay are both two cycles, so the two triggers meet on one edge. The bench then counts handshakes to confirm that only one transfer was consumed.

// File: rtl/dma_trig_pkg.sv
// Package: shared field positions and write-action codes for the DMA
// trigger router. Assumes wr_data is wide enough to hold the control
// fields (2 + trigger-index width bits).
package dma_trig_pkg;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_CHAIN_BIT = 1;
    localparam int CTRL_TSEL_LSB  = 2;

    typedef enum logic [1:0] {
        WR_CTRL = 2'd0,
        WR_SIZE = 2'd1,
        WR_CLR  = 2'd2,
        WR_NONE = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/dma_trig_sync.sv
// Module: two-flop synchroniser for the asynchronous request lines.
// Shared by all channels, so each line is synchronised once. Assumes the
// lines are held high for at least two clock cycles.
module dma_trig_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;

    // Two-stage capture of the raw lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end

endmodule

// File: rtl/dma_trig_channel.sv
// Module: one DMA channel's trigger selection, edge detection, request
// handshake, transfer counter and completion/chain logic.
// Assumes synchronised trigger levels, a chain input that is a single-cycle
// pulse, and that SIZE_W >= TSEL_W + 2.
module dma_trig_channel
    import dma_trig_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    parameter int TSEL_W   = 3,
    parameter int SIZE_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic                size_wr,
    input  logic                clr_wr,
    input  logic [SIZE_W-1:0]   wr_data,
    input  logic [NUM_TRIG-1:0] trig_lvl_i,
    input  logic                chain_i,
    output logic                xfer_req_o,
    input  logic                xfer_done_i,
    output logic                done_o,
    output logic                chain_o
);

    logic              en_q;
    logic              chain_en_q;
    logic [TSEL_W-1:0] tsel_q;
    logic [SIZE_W-1:0] count_q;
    logic              prev_q;

    logic [TSEL_W-1:0] new_tsel;
    logic              new_lvl;
    logic              sel_lvl;
    logic              ext_edge;
    logic              fire;
    logic              handshake;
    logic              last_xfer;
    logic              zero_done;
    logic              complete;
    logic              arm_wr;
    logic              disarm_wr;

    // Decode of the trigger path and completion conditions
    always_comb begin
        new_tsel  = wr_data[CTRL_TSEL_LSB +: TSEL_W];
        new_lvl   = trig_lvl_i[new_tsel];
        sel_lvl   = trig_lvl_i[tsel_q];
        ext_edge  = sel_lvl & ~prev_q;
        fire      = en_q & ~xfer_req_o & (count_q != '0) & (chain_i | ext_edge);
        handshake = xfer_req_o & xfer_done_i;
        last_xfer = handshake & (count_q == SIZE_W'(1));
        zero_done = en_q & ~xfer_req_o & (count_q == '0);
        complete  = last_xfer | zero_done;
        arm_wr    = ctrl_wr & ~en_q & wr_data[CTRL_EN_BIT];
        disarm_wr = ctrl_wr & ~wr_data[CTRL_EN_BIT];
    end

    // Edge history: reloaded on arming so a standing level is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (arm_wr) begin
            prev_q <= new_lvl;
        end else begin
            prev_q <= sel_lvl;
        end
    end

    // Control fields: trigger index locked while enabled, completion disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            chain_en_q <= 1'b0;
            tsel_q     <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q       <= wr_data[CTRL_EN_BIT];
                chain_en_q <= wr_data[CTRL_CHAIN_BIT];
                if (!en_q) begin
                    tsel_q <= new_tsel;
                end
            end
            if (complete) begin
                en_q <= 1'b0;
            end
        end
    end

    // Transfer counter: loaded only while disabled, decremented per handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (size_wr && !en_q) begin
            count_q <= wr_data;
        end else if (handshake) begin
            count_q <= count_q - SIZE_W'(1);
        end
    end

    // Request: one per accepted trigger, held until the done handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_req_o <= 1'b0;
        end else if (disarm_wr || handshake) begin
            xfer_req_o <= 1'b0;
        end else if (fire) begin
            xfer_req_o <= 1'b1;
        end
    end

    // Completion flag (set beats clear) and single-cycle chain pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            chain_o <= 1'b0;
        end else begin
            chain_o <= complete & chain_en_q;
            if (complete) begin
                done_o <= 1'b1;
            end else if (clr_wr) begin
                done_o <= 1'b0;
            end
        end
    end

    AST_TSEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(tsel_q)); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o && !xfer_done_i && !disarm_wr |=> xfer_req_o); // R2

    AST_COUNT_ONLY_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && !handshake |=> $stable(count_q)); // R2

    AST_LAST_XFER_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        last_xfer |=> !en_q && done_o && !xfer_req_o); // R5

    AST_ZERO_COUNT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && (count_q == '0) |-> !xfer_req_o); // R9

    AST_CHAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_o |=> !chain_o); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        complete && clr_wr |=> done_o); // R6

endmodule

// File: rtl/dma_trig_router.sv
// Module: top of the DMA trigger router. Decodes the register write port,
// synchronises the request lines once, and links each channel's chain
// output into the next-higher channel. Assumes SIZE_W >= $clog2(NUM_TRIG)+2.
module dma_trig_router
    import dma_trig_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_TRIG = 8,
    parameter int SIZE_W   = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int TSEL_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_ch,
    input  logic [1:0]          wr_sel,
    input  logic [SIZE_W-1:0]   wr_data,
    input  logic [NUM_TRIG-1:0] trig_i,
    output logic [NUM_CH-1:0]   xfer_req_o,
    input  logic [NUM_CH-1:0]   xfer_done_i,
    output logic [NUM_CH-1:0]   done_o
);

    logic [NUM_TRIG-1:0] trig_sync;
    logic [NUM_CH-1:0]   chain_out;
    logic [NUM_CH-1:0]   chain_in;

    dma_trig_sync #(
        .WIDTH (NUM_TRIG)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_i),
        .sync_o  (trig_sync)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_me;

        // Chain link: channel 0 has none, others listen to the one below
        if (i == 0) begin : g_first
            assign chain_in[i] = 1'b0;
        end else begin : g_next
            assign chain_in[i] = chain_out[i-1];
        end

        assign sel_me = wr_en && (wr_ch == CH_W'(i));

        dma_trig_channel #(
            .NUM_TRIG (NUM_TRIG),
            .TSEL_W   (TSEL_W),
            .SIZE_W   (SIZE_W)
        ) ch_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_wr     (sel_me && (wr_sel == WR_CTRL)),
            .size_wr     (sel_me && (wr_sel == WR_SIZE)),
            .clr_wr      (sel_me && (wr_sel == WR_CLR)),
            .wr_data     (wr_data),
            .trig_lvl_i  (trig_sync),
            .chain_i     (chain_in[i]),
            .xfer_req_o  (xfer_req_o[i]),
            .xfer_done_i (xfer_done_i[i]),
            .done_o      (done_o[i]),
            .chain_o     (chain_out[i])
        );

        AST_CHAIN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            chain_out[i] |-> done_o[i]); // R7
    end

endmodule

// File: tb/dma_trig_router_tb.sv
// Bench: sweeps every channel/trigger-line pairing, several transfer sizes,
// and the same-cycle corner cases; expected values follow the requirements.
module dma_trig_router_tb_top;

    localparam int NCH = 4;
    localparam int NTR = 8;
    localparam int SW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_ch = '0;
    logic [1:0]     wr_sel = '0;
    logic [SW-1:0]  wr_data = '0;
    logic [NTR-1:0] trig = '0;
    logic [NCH-1:0] req;
    logic [NCH-1:0] xdone = '0;
    logic [NCH-1:0] done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_trig_router #(.NUM_CH(NCH), .NUM_TRIG(NTR), .SIZE_W(SW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_ch       (wr_ch),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .trig_i      (trig),
        .xfer_req_o  (req),
        .xfer_done_i (xdone),
        .done_o      (done)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int ctrl(input int en, input int ch_en, input int ts);
        return en + 2 * ch_en + 4 * ts;
    endfunction

    task automatic wr(input int ch, input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = SW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        trig[line] = 1'b1;
        repeat (4) @(negedge clk);
        trig[line] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic hs(input int ch);
        @(negedge clk);
        xdone[ch] = 1'b1;
        @(negedge clk);
        xdone[ch] = 1'b0;
    endtask

    task automatic arm(input int ch, input int size, input int ch_en, input int ts);
        wr(ch, 2, 0);
        wr(ch, 1, size);
        wr(ch, 0, ctrl(1, ch_en, ts));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 req after reset", int'(req), 0);
        chk("R10 done after reset", int'(done), 0);
        wr(0, 0, ctrl(1, 0, 0));
        repeat (3) @(negedge clk);
        chk("R10 count zero after reset: completes at once", int'(done[0]), 1);

        // R1/R5: every channel with every trigger line
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < NTR; t++) begin
                arm(c, 1, 0, t);
                pulse((t + 1) % NTR);
                chk("R1 unselected line ignored", int'(req[c]), 0);
                pulse(t);
                chk("R1 selected line raises request", int'(req), 1 << c);
                hs(c);
                chk("R5 done after last handshake", int'(done[c]), 1);
                chk("R5 request dropped", int'(req[c]), 0);
                pulse(t);
                chk("R5 trigger ignored after completion", int'(req[c]), 0);
            end
        end

        // R2: sizes 1..4, extra trigger while request outstanding is dropped
        for (int n = 1; n <= 4; n++) begin
            arm(1, n, 0, 2);
            for (int k = 1; k <= n; k++) begin
                pulse(2);
                chk("R2 request per trigger", int'(req[1]), 1);
                if (k == 1) begin
                    pulse(2);
                    chk("R2 request held without handshake", int'(req[1]), 1);
                end
                hs(1);
                repeat (4) @(negedge clk);
                chk("R2 request cleared by handshake", int'(req[1]), 0);
                chk("R2 done after n handshakes", int'(done[1]), (k == n) ? 1 : 0);
            end
        end

        // R6: sticky, cleared by write, set wins over same-cycle clear
        repeat (20) @(negedge clk);
        chk("R6 done sticky", int'(done[1]), 1);
        wr(1, 2, 0);
        chk("R6 clear write", int'(done[1]), 0);
        arm(1, 1, 0, 2);
        pulse(2);
        @(negedge clk);
        xdone[1] = 1'b1;
        wr_en = 1'b1; wr_ch = 2'd1; wr_sel = 2'd2; wr_data = '0;
        @(negedge clk);
        xdone[1] = 1'b0;
        wr_en = 1'b0;
        chk("R6 completion beats same-cycle clear", int'(done[1]), 1);

        // R3: trigger index and size locked while enabled
        arm(2, 1, 0, 1);
        wr(2, 0, ctrl(1, 0, 5));
        wr(2, 1, 3);
        pulse(5);
        chk("R3 index write while enabled ignored", int'(req[2]), 0);
        pulse(1);
        chk("R3 original index still active", int'(req[2]), 1);
        hs(2);
        chk("R3 size write while enabled ignored", int'(done[2]), 1);

        // R4: a level already high at arming is not an edge
        @(negedge clk);
        trig[3] = 1'b1;
        repeat (4) @(negedge clk);
        arm(0, 1, 0, 3);
        repeat (6) @(negedge clk);
        chk("R4 standing level ignored", int'(req[0]), 0);
        trig[3] = 1'b0;
        repeat (4) @(negedge clk);
        pulse(3);
        chk("R4 new edge accepted", int'(req[0]), 1);
        hs(0);

        // R7: chain 0 -> 1
        arm(1, 2, 0, 6);
        arm(0, 1, 1, 0);
        pulse(0);
        chk("R7 upstream request", int'(req), 1);
        hs(0);
        repeat (2) @(negedge clk);
        chk("R7 chain starts next channel", int'(req[1]), 1);
        hs(1);
        chk("R7 downstream not done after one", int'(done[1]), 0);
        pulse(6);
        hs(1);
        chk("R7 downstream done", int'(done[1]), 1);

        // R7/R9: chain pulse and external edge on the same edge give one request
        arm(1, 2, 0, 4);
        wr(0, 2, 0);
        wr(0, 1, 0);
        @(negedge clk);
        trig[4] = 1'b1;
        wr_en = 1'b1; wr_ch = 2'd0; wr_sel = 2'd0; wr_data = SW'(ctrl(1, 1, 7));
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        trig[4] = 1'b0;
        chk("R9 zero-size chained channel done", int'(done[0]), 1);
        chk("R7 coincident triggers raise request", int'(req[1]), 1);
        hs(1);
        repeat (4) @(negedge clk);
        chk("R7 coincident triggers counted once", int'(done[1]), 0);
        chk("R7 no second request", int'(req[1]), 0);
        pulse(4);
        hs(1);
        chk("R7 second transfer completes", int'(done[1]), 1);

        // R9: zero size, no request seen at any cycle
        wr(2, 2, 0);
        wr(2, 1, 0);
        begin
            int seen = 0;
            @(negedge clk);
            wr_en = 1'b1; wr_ch = 2'd2; wr_sel = 2'd0; wr_data = SW'(ctrl(1, 0, 0));
            @(negedge clk);
            wr_en = 1'b0;
            for (int i = 0; i < 5; i++) begin
                if (req[2]) seen = 1;
                @(negedge clk);
            end
            chk("R9 zero size raises no request", seen, 0);
            chk("R9 zero size completes", int'(done[2]), 1);
        end

        // R8: last channel's chain reaches nothing
        arm(0, 1, 0, 5);
        arm(3, 1, 1, 2);
        pulse(2);
        hs(3);
        repeat (6) @(negedge clk);
        chk("R8 last channel done", int'(done[3]), 1);
        chk("R8 last chain does not trigger channel 0", int'(req[0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule